// File: doc/BRIEF.md
# Power Rail Sequencer with Fault Capture

This block brings up a board's voltage regulators one at a time. It drives one enable bit per rail and reads one power-good bit per rail. The number of rails is a parameter. When the power request input goes high, the block enables rail 0. It waits for that rail to report good before it enables rail 1, and so on up to the last rail. If the request is dropped, the block turns the rails off from the highest index down, one per tick, and returns to idle.

All decisions are made on a slow internal tick from a free-running divider. The tick period is a parameter, so simulation and debug can use a short one. Power-good inputs pass through a two-flop synchronizer before the state machine reads them. A rail is counted as failed in two cases: it does not come up within a timeout counted in ticks, or it was confirmed good and later loses power-good. Failed rails are recorded in a sticky vector. On a failure the block normally drops every enable at once and parks in a latched-off state that only reset (an input power cycle) clears. While the debug input is high, the shutdown is suppressed and the failures are only recorded.

The state machine has five states:

- `S_OFF`: idle with all rails off. It goes to `S_RAMP_UP` on a tick with the request high.
- `S_RAMP_UP`: one rail is enabled per confirmed power-good.
  - It goes to `S_ALL_ON` once the last rail is confirmed.
  - It goes to `S_RAMP_DOWN` when the request drops.
  - It goes to `S_FAULT` on a timeout or a lost rail, unless debug is high.
- `S_ALL_ON`: every rail is up.
  - It goes to `S_RAMP_DOWN` when the request drops.
  - It goes to `S_FAULT` on a lost rail, unless debug is high.
- `S_RAMP_DOWN`: one rail is disabled per tick, highest index first. It goes to `S_OFF` after rail 0 is off.
- `S_FAULT`: latched off until reset.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, and right after it, all outputs are low: rail_en, failed, all_good and fault.
- R2: While pwr_req is low in the idle state, no rail is enabled.
- R3: With pwr_req high, rails are enabled in ascending index order. rail_en is always of the form 2^k-1, and the next rail is enabled only after the current rail's power-good is seen.
- R4: rail_en changes only on an internal tick. Successive sequencing steps are exactly TICK_DIV clocks apart.
- R5: all_good is high exactly when every rail has been confirmed and the block is in `S_ALL_ON`. rail_en is then all ones.
- R6: If the rail just enabled does not report power-good within TIMEOUT_TICKS ticks, its bit is set in failed. With debug low, all enables are then dropped and fault goes high.
- R7: If a confirmed rail loses power-good, its bit is set in failed. With debug low, all enables drop on the next tick and fault goes high. Bits in failed never clear until reset.
- R8: With debug_en high, R6 and R7 still record the rail in failed. The enables stay as they are, fault stays low, and a timed-out step keeps waiting.
- R9: Once fault is high, it and the all-off enables hold regardless of pwr_req until reset.
- R10: Dropping pwr_req disables rails from the highest enabled index down, one per tick. all_good and fault are low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; models input power cycle |
| pwr_req | input | 1 | Main power-on request |
| debug_en | input | 1 | Suppresses emergency shutdown when high |
| pg_in | input | N_RAILS | Raw power-good per rail, asynchronous |
| rail_en | output | N_RAILS | Regulator enable per rail |
| failed | output | N_RAILS | Sticky record of failed rails |
| all_good | output | 1 | All rails up |
| fault | output | 1 | Latched emergency-off state |

## Verification
A change on pg_in reaches the state machine two clocks later through the synchronizer. It then acts at the next tick, and the registered outputs change on that tick edge. Each result is therefore due no later than one tick period plus two clocks after the stimulus. Timeouts add TIMEOUT_TICKS ticks on top of that.

The vector walk and the fault tests sample only after a settle window of many ticks. The ordering tests watch rail_en on every falling edge. They check each change against the previous value and measure the clock gap between changes, so they never need to know the tick phase.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    typedef enum logic [2:0] {
        S_OFF,
        S_RAMP_UP,
        S_ALL_ON,
        S_RAMP_DOWN,
        S_FAULT
    } rseq_state_e;
endpackage

// File: rtl/rseq_tick.sv
module rseq_tick #(
    parameter int TICK_DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rseq_sync.sv
module rseq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int N_RAILS       = 8,
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req,
    input  logic               dbg,
    input  logic [N_RAILS-1:0] pg_s,
    output logic [N_RAILS-1:0] rail_en,
    output logic [N_RAILS-1:0] failed,
    output logic               all_good,
    output logic               fault
);
    localparam int IW = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);

    rseq_state_e       state_q, state_d;
    logic [IW-1:0]      idx_q, idx_d;
    logic [TW-1:0]      tmo_q, tmo_d;
    logic [N_RAILS-1:0] en_q, en_d;
    logic [N_RAILS-1:0] up_q, up_d;
    logic [N_RAILS-1:0] fail_q, fail_d;
    logic [N_RAILS-1:0] lost;

    assign lost = up_q & ~pg_s;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        tmo_d   = tmo_q;
        en_d    = en_q;
        up_d    = up_q;
        fail_d  = fail_q;
        unique case (state_q)
            S_OFF: begin
                if (tick && req) begin
                    en_d[0] = 1'b1;
                    idx_d   = '0;
                    tmo_d   = '0;
                    state_d = S_RAMP_UP;
                end
            end
            S_RAMP_UP: begin
                if (tick) begin
                    fail_d = fail_q | lost;
                    if ((|lost) && !dbg) begin
                        en_d    = '0;
                        up_d    = '0;
                        state_d = S_FAULT;
                    end else if (!req) begin
                        state_d = S_RAMP_DOWN;
                    end else if (pg_s[idx_q]) begin
                        up_d[idx_q] = 1'b1;
                        if (idx_q == IW'(N_RAILS - 1)) begin
                            state_d = S_ALL_ON;
                        end else begin
                            idx_d             = idx_q + 1'b1;
                            en_d[idx_q + 1'b1] = 1'b1;
                            tmo_d             = '0;
                        end
                    end else if (tmo_q >= TW'(TIMEOUT_TICKS - 1)) begin
                        fail_d[idx_q] = 1'b1;
                        if (!dbg) begin
                            en_d    = '0;
                            up_d    = '0;
                            state_d = S_FAULT;
                        end
                    end else begin
                        tmo_d = tmo_q + 1'b1;
                    end
                end
            end
            S_ALL_ON: begin
                if (tick) begin
                    fail_d = fail_q | lost;
                    if ((|lost) && !dbg) begin
                        en_d    = '0;
                        up_d    = '0;
                        state_d = S_FAULT;
                    end else if (!req) begin
                        state_d = S_RAMP_DOWN;
                    end
                end
            end
            S_RAMP_DOWN: begin
                if (tick) begin
                    en_d[idx_q] = 1'b0;
                    up_d[idx_q] = 1'b0;
                    if (idx_q == '0) state_d = S_OFF;
                    else             idx_d   = idx_q - 1'b1;
                end
            end
            S_FAULT: begin
                en_d = '0;
                up_d = '0;
            end
            default: state_d = S_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            idx_q   <= '0;
            tmo_q   <= '0;
            en_q    <= '0;
            up_q    <= '0;
            fail_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            tmo_q   <= tmo_d;
            en_q    <= en_d;
            up_q    <= up_d;
            fail_q  <= fail_d;
        end
    end

    always_comb begin
        rail_en  = en_q;
        failed   = fail_q;
        all_good = (state_q == S_ALL_ON);
        fault    = (state_q == S_FAULT);
    end

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAULT) |-> (en_q == '0));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAULT) |=> (state_q == S_FAULT));

    // R4
    en_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(en_q));

    // R3
    en_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q + {{(N_RAILS-1){1'b0}}, 1'b1}) & en_q) == '0);

    // R7
    failed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((fail_q & $past(fail_q)) == $past(fail_q)));

    // R5
    all_good_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_good |-> (&en_q));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
    parameter int N_RAILS       = 8,
    parameter int TICK_DIV      = 4096,
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_req,
    input  logic               debug_en,
    input  logic [N_RAILS-1:0] pg_in,
    output logic [N_RAILS-1:0] rail_en,
    output logic [N_RAILS-1:0] failed,
    output logic               all_good,
    output logic               fault
);
    logic               tick;
    logic [N_RAILS-1:0] pg_s;

    rseq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rseq_sync #(.WIDTH(N_RAILS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pg_in),
        .q_o   (pg_s)
    );

    rseq_fsm #(.N_RAILS(N_RAILS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .req      (pwr_req),
        .dbg      (debug_en),
        .pg_s     (pg_s),
        .rail_en  (rail_en),
        .failed   (failed),
        .all_good (all_good),
        .fault    (fault)
    );
endmodule

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;
    localparam int N   = 8;
    localparam int DIV = 4;
    localparam int TMO = 3;

    typedef struct packed {
        logic       req;
        logic       dbg;
        logic [7:0] bad;
        logic [7:0] en;
        logic [7:0] fl;
        logic       ag;
        logic       ft;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 8'h08, 8'h00, 8'h08, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'h08, 8'h0F, 8'h08, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h80, 8'h00, 8'h80, 1'b0, 1'b1}
    };
    localparam string TAGS [5] = '{"R2", "R3", "R6", "R8", "R6"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_req = 1'b0;
    logic         debug_en = 1'b0;
    logic [N-1:0] bad = '0;
    logic [N-1:0] pg_in;
    logic [N-1:0] rail_en;
    logic [N-1:0] failed;
    logic         all_good;
    logic         fault;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign pg_in = rail_en & ~bad;

    rail_sequencer #(.N_RAILS(N), .TICK_DIV(DIV), .TIMEOUT_TICKS(TMO)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_req  (pwr_req),
        .debug_en (debug_en),
        .pg_in    (pg_in),
        .rail_en  (rail_en),
        .failed   (failed),
        .all_good (all_good),
        .fault    (fault)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        pwr_req  = 1'b0;
        debug_en = 1'b0;
        bad      = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] prev;
        int         gap;
        int         changes;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 en", rail_en, 8'h00);
        check("R1 failed", failed, 8'h00);
        check("R1 all_good", {7'd0, all_good}, 8'h00);
        check("R1 fault", {7'd0, fault}, 8'h00);

        // vector walk
        for (int i = 0; i < 5; i++) begin
            do_reset();
            pwr_req  = VEC[i].req;
            debug_en = VEC[i].dbg;
            bad      = VEC[i].bad;
            repeat (80) @(negedge clk);
            check(TAGS[i], rail_en, VEC[i].en);
            check(TAGS[i], failed, VEC[i].fl);
            check("R5", {7'd0, all_good}, {7'd0, VEC[i].ag});
            check("R9", {7'd0, fault}, {7'd0, VEC[i].ft});
        end

        // R3 R4: bring-up order and pacing
        do_reset();
        pwr_req = 1'b1;
        prev = 8'h00; gap = 0; changes = 0;
        for (int c = 0; c < 200 && prev != 8'hFF; c++) begin
            @(negedge clk);
            gap++;
            if (rail_en != prev) begin
                check("R3 up order", rail_en, {prev[6:0], 1'b1});
                if (changes > 0) check("R4 up gap", 8'(gap), 8'(DIV));
                changes++;
                gap  = 0;
                prev = rail_en;
            end
        end
        check("R3 up count", 8'(changes), 8'd8);
        repeat (2 * DIV + 4) @(negedge clk);
        check("R5 all_good", {7'd0, all_good}, 8'h01);

        // R10: power-down order and pacing
        pwr_req = 1'b0;
        gap = 0; changes = 0;
        for (int c = 0; c < 200 && prev != 8'h00; c++) begin
            @(negedge clk);
            gap++;
            if (rail_en != prev) begin
                check("R10 down order", rail_en, {1'b0, prev[7:1]});
                if (changes > 0) check("R10 down gap", 8'(gap), 8'(DIV));
                changes++;
                gap  = 0;
                prev = rail_en;
            end
        end
        check("R10 down count", 8'(changes), 8'd8);
        check("R10 all_good", {7'd0, all_good}, 8'h00);
        check("R10 fault", {7'd0, fault}, 8'h00);

        // R7: runtime loss shuts down
        do_reset();
        pwr_req = 1'b1;
        repeat (80) @(negedge clk);
        bad = 8'h04;
        repeat (8 * DIV) @(negedge clk);
        check("R7 en", rail_en, 8'h00);
        check("R7 failed", failed, 8'h04);
        check("R7 fault", {7'd0, fault}, 8'h01);

        // R9: request toggling ignored while latched off
        bad = 8'h00;
        pwr_req = 1'b0;
        repeat (40) @(negedge clk);
        pwr_req = 1'b1;
        repeat (80) @(negedge clk);
        check("R9 en", rail_en, 8'h00);
        check("R9 fault", {7'd0, fault}, 8'h01);
        check("R9 failed", failed, 8'h04);

        // R8: debug keeps rails on after runtime loss
        do_reset();
        debug_en = 1'b1;
        pwr_req  = 1'b1;
        repeat (80) @(negedge clk);
        bad = 8'h20;
        repeat (8 * DIV) @(negedge clk);
        check("R8 en", rail_en, 8'hFF);
        check("R8 failed", failed, 8'h20);
        check("R8 fault", {7'd0, fault}, 8'h00);

        // R1: reset clears latched fault
        do_reset();
        @(negedge clk);
        check("R1 fault after reset", {7'd0, fault}, 8'h00);
        check("R1 failed after reset", failed, 8'h00);

        finish_run();
    end
endmodule